// File: doc/BRIEF.md
# Load Return Data Formatter

This block sits on the return side of a vector memory pipeline. When load data for one wavefront arrives, it writes that data into the vector register file. Each element is converted from its memory type to the width of the destination register. Integer types are zero-extended or sign-extended. Narrow floating-point types are widened exactly. The write is gated by the wavefront's per-lane execute mask.

A load is launched with a single-cycle `start` pulse. The pulse carries the raw data buffer, the memory element kind, the destination width, a base register index, a register count and the execute mask. The block captures all of these. Starting on the next cycle, it presents one destination register per cycle, with every lane in parallel. `done` accompanies the final register. A configuration that cannot be formatted is refused with a one-cycle `err` pulse, and nothing is written.

The buffer holds `LANES*MAX_REGS` slots of 64 bits each. The element for destination register k and lane i sits in the low bits of slot `k*LANES+i`, which occupies buffer bits `[(k*LANES+i)*64 +: 64]`.

Top module: `lrf_load_formatter`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low and `wr_en` is all zero.
- R2: Unsigned kinds are zero-extended to the destination width. The codes are 0 (8-bit), 1 (16-bit), 2 (32-bit) and 3 (64-bit). A 32-bit destination is selected by `dst_wide`=0 and is placed in `wr_data` bits [31:0] with bits [63:32] zero. A 64-bit destination is selected by `dst_wide`=1.
- R3: Signed kinds are sign-extended to the destination width. The codes are 4 (8-bit), 5 (16-bit), 6 (32-bit) and 7 (64-bit).
- R4: Kind 8 (half precision) widens exactly to single precision on a 32-bit destination and to double precision on a 64-bit destination. This covers signed zero, subnormals, infinities and NaN payloads.
- R5: Kind 9 (single precision) widens exactly to double precision on a 64-bit destination and is copied unchanged to a 32-bit destination. Kind 10 (double precision) is copied unchanged.
- R6: Some `start` pulses are refused. This happens for kind codes 11 to 15, for any 64-bit kind (3, 7, 10) with `dst_wide`=0, for a count of zero, for a count above `MAX_REGS`, and when count times element bits exceeds `MAX_LANE_BITS`. A refused pulse raises `err` for exactly the cycle after it and produces no write and no `busy`.
- R7: An accepted start presents register k, for k from 0 to count-1, in the k+1-th cycle after the start edge, with `wr_idx` = `base_reg`+k. Lane i carries the element from buffer slot k*LANES+i.
- R8: `wr_en[i]` is high during a register cycle only when bit i of the captured execute mask is set.
- R9: `done` is high in the cycle of the last register only, and `busy` is high in exactly the register cycles.
- R10: A `start` pulse while `busy` is high is ignored. The running sequence keeps its index, count, data and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse; captures all configuration inputs |
| mem_kind | input | 4 | Memory element kind code |
| dst_wide | input | 1 | 1 = 64-bit destination, 0 = 32-bit |
| base_reg | input | IDX_W | First destination register index |
| reg_cnt | input | CNT_W | Number of destination registers |
| exec_mask | input | LANES | Per-lane execute mask |
| data_buf | input | LANES*MAX_REGS*64 | Raw returned data, one 64-bit slot per element |
| busy | output | 1 | A register is being presented this cycle |
| wr_en | output | LANES | Per-lane write strobe |
| wr_idx | output | IDX_W | Destination register index |
| wr_data | output | LANES*64 | Formatted data, lane i in bits [i*64 +: 64] |
| done | output | 1 | Last register of the sequence |
| err | output | 1 | Refused configuration, one cycle |

## Verification
The assertions assume that `start` is a single-cycle pulse. They also assume that the index arithmetic `base_reg`+count never wraps within a sequence. The stimulus respects both: each pulse lasts one cycle, and random base indices stay small enough that the last register fits below the index limit. Random runs choose only legal kind and width pairs, with counts bounded by both the register limit and the per-lane bit budget. Refused configurations and starts during a sequence are applied only as directed cases, each paired with checks on the outputs that could have been disturbed.

// File: rtl/lrf_pkg.sv
package lrf_pkg;

    localparam int SLOT_W = 64;

    typedef enum logic [3:0] {
        MK_U8  = 4'd0,
        MK_U16 = 4'd1,
        MK_U32 = 4'd2,
        MK_U64 = 4'd3,
        MK_S8  = 4'd4,
        MK_S16 = 4'd5,
        MK_S32 = 4'd6,
        MK_S64 = 4'd7,
        MK_F16 = 4'd8,
        MK_F32 = 4'd9,
        MK_F64 = 4'd10
    } mem_kind_e;

    // element width in bits; zero marks an undefined code
    function automatic int unsigned kind_bits(logic [3:0] k);
        case (k)
            MK_U8,  MK_S8:           return 8;
            MK_U16, MK_S16, MK_F16:  return 16;
            MK_U32, MK_S32, MK_F32:  return 32;
            MK_U64, MK_S64, MK_F64:  return 64;
            default:                 return 0;
        endcase
    endfunction

    function automatic logic kind_fits(logic [3:0] k, logic wide);
        int unsigned b;
        b = kind_bits(k);
        return (b != 0) && (wide || b <= 32);
    endfunction

    // position of the highest set bit of a nonzero mantissa
    function automatic int unsigned top_one(logic [22:0] m);
        int unsigned p;
        p = 0;
        for (int i = 0; i < 23; i++) begin
            if (m[i]) p = i;
        end
        return p;
    endfunction

    function automatic logic [31:0] half_to_single(logic [15:0] h);
        logic [4:0]  e;
        logic [9:0]  m;
        logic [9:0]  mm;
        int unsigned p;
        e = h[14:10];
        m = h[9:0];
        if (e == 5'h1F) return {h[15], 8'hFF, m, 13'b0};
        if (e == 5'h00) begin
            if (m == 10'b0) return {h[15], 31'b0};
            p  = top_one({13'b0, m});
            mm = 10'({m, 10'b0} >> p);
            return {h[15], 8'(p + 103), mm, 13'b0};
        end
        return {h[15], 8'({3'b0, e} + 8'd112), m, 13'b0};
    endfunction

    function automatic logic [63:0] half_to_double(logic [15:0] h);
        logic [4:0]  e;
        logic [9:0]  m;
        logic [9:0]  mm;
        int unsigned p;
        e = h[14:10];
        m = h[9:0];
        if (e == 5'h1F) return {h[15], 11'h7FF, m, 42'b0};
        if (e == 5'h00) begin
            if (m == 10'b0) return {h[15], 63'b0};
            p  = top_one({13'b0, m});
            mm = 10'({m, 10'b0} >> p);
            return {h[15], 11'(p + 999), mm, 42'b0};
        end
        return {h[15], 11'({6'b0, e} + 11'd1008), m, 42'b0};
    endfunction

    function automatic logic [63:0] single_to_double(logic [31:0] s);
        logic [7:0]  e;
        logic [22:0] m;
        logic [22:0] mm;
        int unsigned p;
        e = s[30:23];
        m = s[22:0];
        if (e == 8'hFF) return {s[31], 11'h7FF, m, 29'b0};
        if (e == 8'h00) begin
            if (m == 23'b0) return {s[31], 63'b0};
            p  = top_one(m);
            mm = 23'({m, 23'b0} >> p);
            return {s[31], 11'(p + 874), mm, 29'b0};
        end
        return {s[31], 11'({3'b0, e} + 11'd896), m, 29'b0};
    endfunction

    function automatic logic [63:0] format_elem(logic [3:0] k, logic wide,
                                                logic [63:0] r);
        logic [63:0] o;
        case (k)
            MK_U8:  o = {56'b0, r[7:0]};
            MK_U16: o = {48'b0, r[15:0]};
            MK_U32: o = {32'b0, r[31:0]};
            MK_U64: o = r;
            MK_S8:  o = {{56{r[7]}},  r[7:0]};
            MK_S16: o = {{48{r[15]}}, r[15:0]};
            MK_S32: o = {{32{r[31]}}, r[31:0]};
            MK_S64: o = r;
            MK_F16: o = wide ? half_to_double(r[15:0])
                             : {32'b0, half_to_single(r[15:0])};
            MK_F32: o = wide ? single_to_double(r[31:0]) : {32'b0, r[31:0]};
            MK_F64: o = r;
            default: o = '0;
        endcase
        if (!wide) o[63:32] = '0;
        return o;
    endfunction

endpackage

// File: rtl/lrf_lane_conv.sv
module lrf_lane_conv
    import lrf_pkg::*;
(
    input  logic [3:0]        kind,
    input  logic              wide,
    input  logic [SLOT_W-1:0] raw,
    output logic [SLOT_W-1:0] fmt
);

    always_comb begin
        fmt = format_elem(kind, wide, raw);
    end

    always_comb begin
        // R2
        narrow_upper_zero_chk: assert (wide || fmt[63:32] == 32'b0);
        // R3
        neg_byte_fill_chk: assert (!(kind == MK_S8 && raw[7])
                                   || fmt[31:8] == 24'hFF_FFFF);
    end

endmodule

// File: rtl/lrf_seq.sv
module lrf_seq #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cfg_ok,
    input  logic [CNT_W-1:0] cnt_in,
    output logic             run,
    output logic [CNT_W-1:0] step,
    output logic             last,
    output logic             err
);

    logic [CNT_W-1:0] cnt_q;

    assign last = run && (step == cnt_q - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            step  <= '0;
            cnt_q <= '0;
            err   <= 1'b0;
        end else begin
            err <= 1'b0;
            if (run) begin
                if (last) run <= 1'b0;
                else      step <= step + CNT_W'(1);
            end else if (start) begin
                if (cfg_ok) begin
                    run   <= 1'b1;
                    step  <= '0;
                    cnt_q <= cnt_in;
                end else begin
                    err <= 1'b1;
                end
            end
        end
    end

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        last |=> !last);
    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (run && start) |=> $stable(cnt_q));
    // R6
    err_single_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !run);

endmodule

// File: rtl/lrf_load_formatter.sv
module lrf_load_formatter
    import lrf_pkg::*;
#(
    parameter int LANES         = 4,
    parameter int MAX_REGS      = 4,
    parameter int IDX_W         = 8,
    parameter int MAX_LANE_BITS = 128,
    localparam int CNT_W        = $clog2(MAX_REGS + 1),
    localparam int BUF_W        = LANES * MAX_REGS * SLOT_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [3:0]              mem_kind,
    input  logic                    dst_wide,
    input  logic [IDX_W-1:0]        base_reg,
    input  logic [CNT_W-1:0]        reg_cnt,
    input  logic [LANES-1:0]        exec_mask,
    input  logic [BUF_W-1:0]        data_buf,
    output logic                    busy,
    output logic [LANES-1:0]        wr_en,
    output logic [IDX_W-1:0]        wr_idx,
    output logic [LANES*SLOT_W-1:0] wr_data,
    output logic                    done,
    output logic                    err
);

    logic             cfg_ok;
    logic             run;
    logic             last;
    logic [CNT_W-1:0] step;
    logic [3:0]       kind_q;
    logic             wide_q;
    logic [IDX_W-1:0] base_q;
    logic [LANES-1:0] mask_q;
    logic [BUF_W-1:0] buf_q;

    always_comb begin
        int unsigned eb;
        eb = kind_bits(mem_kind);
        cfg_ok = kind_fits(mem_kind, dst_wide)
              && (reg_cnt != '0)
              && (int'(reg_cnt) <= MAX_REGS)
              && (int'(reg_cnt) * eb <= MAX_LANE_BITS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= '0;
            wide_q <= 1'b0;
            base_q <= '0;
            mask_q <= '0;
            buf_q  <= '0;
        end else if (start && !run && cfg_ok) begin
            kind_q <= mem_kind;
            wide_q <= dst_wide;
            base_q <= base_reg;
            mask_q <= exec_mask;
            buf_q  <= data_buf;
        end
    end

    lrf_seq #(.CNT_W(CNT_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cfg_ok (cfg_ok),
        .cnt_in (reg_cnt),
        .run    (run),
        .step   (step),
        .last   (last),
        .err    (err)
    );

    assign busy   = run;
    assign done   = last;
    assign wr_idx = base_q + IDX_W'(step);
    assign wr_en  = run ? mask_q : '0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SLOT_W-1:0] raw;
        assign raw = buf_q[(int'(step) * LANES + i) * SLOT_W +: SLOT_W];
        lrf_lane_conv u_conv (
            .kind (kind_q),
            .wide (wide_q),
            .raw  (raw),
            .fmt  (wr_data[i*SLOT_W +: SLOT_W])
        );
    end

    // R6
    err_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (wr_en == '0 && !done));
    // R7
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy && wr_idx == $past(wr_idx) + IDX_W'(1)));
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (wr_en == '0));

endmodule

// File: tb/lrf_load_formatter_bench.sv
module lrf_load_formatter_bench;

    localparam int LANES = 4;
    localparam int MAXR  = 4;
    localparam int IDXW  = 8;
    localparam int CNTW  = $clog2(MAXR + 1);
    localparam int NSLOT = LANES * MAXR;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  start = 1'b0;
    logic [3:0]            mem_kind = '0;
    logic                  dst_wide = 1'b0;
    logic [IDXW-1:0]       base_reg = '0;
    logic [CNTW-1:0]       reg_cnt = '0;
    logic [LANES-1:0]      exec_mask = '0;
    logic [NSLOT*64-1:0]   data_buf = '0;
    logic                  busy;
    logic [LANES-1:0]      wr_en;
    logic [IDXW-1:0]       wr_idx;
    logic [LANES*64-1:0]   wr_data;
    logic                  done;
    logic                  err;

    logic [63:0] slots [NSLOT];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lrf_load_formatter u_lrf_load_formatter (
        .clk(clk), .rst(rst), .start(start), .mem_kind(mem_kind),
        .dst_wide(dst_wide), .base_reg(base_reg), .reg_cnt(reg_cnt),
        .exec_mask(exec_mask), .data_buf(data_buf), .busy(busy),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .done(done), .err(err)
    );

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ebits(int k);
        if (k == 0 || k == 4) return 8;
        if (k == 1 || k == 5 || k == 8) return 16;
        if (k == 2 || k == 6 || k == 9) return 32;
        return 64;
    endfunction

    function automatic logic [63:0] h_to_d(logic [15:0] h);
        int e = int'(h[14:10]);
        real v;
        logic [63:0] b;
        if (e == 31) return {h[15], 11'h7FF, h[9:0], 42'b0};
        if (e == 0) v = real'(h[9:0]) * (2.0 ** (-24.0));
        else        v = real'(1024 + int'(h[9:0])) * (2.0 ** real'(e - 25));
        b = $realtobits(v);
        b[63] = h[15];
        return b;
    endfunction

    function automatic logic [31:0] h_to_s(logic [15:0] h);
        logic [63:0] d;
        logic [10:0] de;
        if (h[14:10] == 5'h1F) return {h[15], 8'hFF, h[9:0], 13'b0};
        d = h_to_d(h);
        if (d[62:0] == '0) return {h[15], 31'b0};
        de = d[62:52] - 11'd896;
        return {d[63], de[7:0], d[51:29]};
    endfunction

    function automatic logic [63:0] s_to_d(logic [31:0] s);
        int e = int'(s[30:23]);
        real v;
        logic [63:0] b;
        if (e == 255) return {s[31], 11'h7FF, s[22:0], 29'b0};
        if (e == 0) v = real'(s[22:0]) * (2.0 ** (-149.0));
        else        v = real'(8388608 + int'(s[22:0])) * (2.0 ** real'(e - 150));
        b = $realtobits(v);
        b[63] = s[31];
        return b;
    endfunction

    function automatic logic [63:0] ref_fmt(int k, bit wide, logic [63:0] r);
        logic [63:0] o;
        int b = ebits(k);
        logic [63:0] lowmask = (b == 64) ? '1 : ((64'd1 << b) - 64'd1);
        if (k <= 3) o = r & lowmask;
        else if (k <= 7) o = (r[b-1]) ? (r | ~lowmask) : (r & lowmask);
        else if (k == 8) o = wide ? h_to_d(r[15:0]) : {32'b0, h_to_s(r[15:0])};
        else if (k == 9) o = wide ? s_to_d(r[31:0]) : {32'b0, r[31:0]};
        else o = r;
        if (!wide) o[63:32] = '0;
        return o;
    endfunction

    function automatic string tag_of(int k);
        if (k <= 3) return "R2";
        if (k <= 7) return "R3";
        if (k == 8) return "R4";
        return "R5";
    endfunction

    task automatic load_buf();
        for (int s = 0; s < NSLOT; s++) data_buf[s*64 +: 64] = slots[s];
    endtask

    // launches one operation and checks every cycle of it
    task automatic run_op(int k, bit wide, int base, int cnt, logic [LANES-1:0] m,
                          bit expect_err, bit poke);
        @(negedge clk);
        load_buf();
        mem_kind = 4'(k); dst_wide = wide; base_reg = IDXW'(base);
        reg_cnt = CNTW'(cnt); exec_mask = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (expect_err) begin
            chk(err == 1'b1, "R6 err pulse", 64'(err), 64'd1);
            chk(wr_en == '0 && !busy, "R6 no write", 64'(wr_en), 64'd0);
            @(negedge clk);
            chk(err == 1'b0 && !busy, "R6 err one cycle", 64'(err), 64'd0);
            return;
        end
        for (int r = 0; r < cnt; r++) begin
            chk(busy == 1'b1, "R9 busy", 64'(busy), 64'd1);
            chk(wr_idx == IDXW'(base + r), "R7 index", 64'(wr_idx), 64'(base + r));
            chk(wr_en == m, "R8 lane strobes", 64'(wr_en), 64'(m));
            chk(done == (r == cnt - 1), "R9 done", 64'(done), 64'(r == cnt - 1));
            for (int i = 0; i < LANES; i++) begin
                if (m[i]) begin
                    logic [63:0] exp = ref_fmt(k, wide, slots[r*LANES + i]);
                    chk(wr_data[i*64 +: 64] == exp, {tag_of(k), " R7 lane data"},
                        wr_data[i*64 +: 64], exp);
                end
            end
            if (poke && r == 0) begin
                // R10: a second start with a different setup during the run
                mem_kind = 4'(k == 0 ? 1 : 0); base_reg = IDXW'(base + 77);
                reg_cnt = CNTW'(1); exec_mask = ~m; start = 1'b1;
                for (int s = 0; s < NSLOT; s++) data_buf[s*64 +: 64] = ~slots[s];
            end
            @(negedge clk);
            start = 1'b0;
        end
        chk(!busy && !done && wr_en == '0, "R9 idle after last", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed = 32'h1F2E;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        chk(!busy && !done && !err && wr_en == '0, "R1 reset state",
            {wr_en, busy, done, err}, 64'd0);

        // R4 half specials, both widths
        slots[0] = 64'h0000; slots[1] = 64'h8000; slots[2] = 64'h0001; slots[3] = 64'h03FF;
        slots[4] = 64'h7C00; slots[5] = 64'hFC00; slots[6] = 64'h7E01; slots[7] = 64'h3C00;
        for (int s = 8; s < NSLOT; s++) slots[s] = 64'h0;
        run_op(8, 1'b0, 10, 2, 4'hF, 1'b0, 1'b0);
        run_op(8, 1'b1, 20, 2, 4'hF, 1'b0, 1'b0);

        // R5 single specials to double
        slots[0] = 64'h0000_0001; slots[1] = 64'h7F80_0000; slots[2] = 64'h7FC0_0123;
        slots[3] = 64'h8000_0000; slots[4] = 64'h0040_0000; slots[5] = 64'h3F80_0000;
        slots[6] = 64'hFF7F_FFFF; slots[7] = 64'h807F_FFFF;
        run_op(9, 1'b1, 30, 2, 4'hF, 1'b0, 1'b0);

        // R3 negative extremes, R2 top bits set
        for (int s = 0; s < NSLOT; s++) slots[s] = 64'hFFFF_FFFF_FFFF_FF80;
        run_op(4, 1'b1, 40, 4, 4'hF, 1'b0, 1'b0);
        run_op(1, 1'b0, 50, 4, 4'hF, 1'b0, 1'b0);

        // R8 empty mask, partial mask
        run_op(6, 1'b0, 60, 3, 4'h0, 1'b0, 1'b0);
        run_op(2, 1'b1, 70, 2, 4'b1010, 1'b0, 1'b0);

        // R6 refusals
        run_op(3, 1'b0, 0, 1, 4'hF, 1'b1, 1'b0);
        run_op(10, 1'b0, 0, 1, 4'hF, 1'b1, 1'b0);
        run_op(12, 1'b1, 0, 1, 4'hF, 1'b1, 1'b0);
        run_op(0, 1'b1, 0, 0, 4'hF, 1'b1, 1'b0);
        run_op(0, 1'b1, 0, 5, 4'hF, 1'b1, 1'b0);
        run_op(7, 1'b1, 0, 3, 4'hF, 1'b1, 1'b0);

        // R10 start while busy
        for (int s = 0; s < NSLOT; s++) slots[s] = {$urandom, $urandom};
        run_op(5, 1'b1, 90, 4, 4'b0110, 1'b0, 1'b1);

        // random legal runs
        for (int t = 0; t < 60; t++) begin
            bit w = 1'($urandom % 2);
            int k;
            int mx;
            int narrow_kinds [8] = '{0, 1, 2, 4, 5, 6, 8, 9};
            if (w) k = int'($urandom % 11);
            else   k = narrow_kinds[$urandom % 8];
            mx = 128 / ebits(k);
            if (mx > MAXR) mx = MAXR;
            for (int s = 0; s < NSLOT; s++) slots[s] = {$urandom, $urandom};
            run_op(k, w, int'($urandom % 200), 1 + int'($urandom % mx),
                   4'($urandom), 1'b0, 1'b0);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule